// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This controller decides which rail feeds the cache backup regulator: the auxiliary system rail or the backup battery. It watches a set of digital flags from analog comparators elsewhere on the die. It drives two power-mux gate commands, a regulator run command and a dormant indication. Every change of source is break-before-make. The controller opens the closed switch, waits a fixed number of clock cycles with neither source connected, and then closes the switch for whichever source the auxiliary flag selects at that moment.

If the battery runs low while it is carrying the regulator, the controller enters a latched low-current dormant state. In that state both switches are open and the regulator is stopped. It leaves dormancy only when system power is back, which means the auxiliary rail is above its trip point and the regulator undervoltage lockout has cleared. The regulator runs only when its active-low enable is asserted and a source is connected. It also stops whenever its undervoltage lockout or over-temperature flag is raised.

All outputs are registered. The gap length is the parameter `GAP_CYC`, counted in clock cycles (100 cycles gives 1 µs at 100 MHz).

Top module: `bkup_src_ctrl`

## Requirements
- R1: While reset is high and after its release, both switches are open, the run command is low and the dormant indication is low. The first switch closes exactly `GAP_CYC` clock edges after the first edge with reset low counted as edge 1. It is the auxiliary switch if `aux_ok_i`=1 at that edge, and the battery switch otherwise.
- R2: When the auxiliary switch is closed and `aux_ok_i`=0 is sampled, the auxiliary switch opens at that edge. The battery switch closes `GAP_CYC` edges later. The return from battery to auxiliary on `aux_ok_i`=1 follows the same timing.
- R3: `aux_sw_o` and `bat_sw_o` are never high in the same cycle.
- R4: A source request that changes during a gap never shortens the gap. Both switches stay open for the full `GAP_CYC` cycles, and the switch closed at the end is the one selected by `aux_ok_i` at the closing edge.
- R5: `reg_run_o` is high only when `reg_en_n_i` was sampled low and a source is connected. It changes at the same edge as the switches. With `reg_en_n_i`=1, `reg_run_o` is 0 at the next edge and the switches are unaffected.
- R6: When the battery switch is closed and `batt_low_i`=1 is sampled, `dormant_o` rises at that edge. The battery switch and `reg_run_o` fall at that same edge.
- R7: Dormancy is latched. Deasserting `batt_low_i` does not clear it, and neither does `aux_ok_i`=1 while `reg_uvlo_i`=1. It clears at the edge where `aux_ok_i`=1 and `reg_uvlo_i`=0 are sampled together. The auxiliary switch then closes `GAP_CYC` edges later.
- R8: `reg_hot_i`=1 forces `reg_run_o` to 0 at the next edge without moving the switches. Running resumes at the edge after the flag clears.
- R9: `batt_low_i` has no effect while the auxiliary switch is closed. Switches, run command and dormant indication are unchanged.
- R10: `reg_uvlo_i`=1 forces `reg_run_o` to 0 at the next edge without moving the switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_ok_i | input | 1 | Auxiliary rail above trip threshold (hysteresis-filtered) |
| batt_low_i | input | 1 | Scaled battery below low-battery setting |
| reg_uvlo_i | input | 1 | Regulator undervoltage lockout active |
| reg_hot_i | input | 1 | Regulator over-temperature (comparator with hysteresis) |
| reg_en_n_i | input | 1 | Active-low regulator enable |
| aux_sw_o | output | 1 | Gate command, auxiliary mux switch |
| bat_sw_o | output | 1 | Gate command, battery mux switch |
| reg_run_o | output | 1 | Regulator run command |
| dormant_o | output | 1 | Latched low-battery dormant state |

## Verification
Every result is due a fixed number of edges after the input change that causes it. Switch openings, run-command changes, dormancy entry and dormancy exit appear one edge after the input is sampled. A switch closure appears `GAP_CYC` edges after the opening edge, or after the wake edge when leaving dormancy. The driver changes inputs just after a falling edge and, at that moment, pushes each expected output tuple tagged with its absolute due cycle. This includes the last all-open cycle of every gap and the closing cycle. The monitor compares each tuple only at the falling edge of its due cycle, so an early or late closure is reported as a mismatch.

// File: rtl/bkup_pkg.sv
package bkup_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_GAP  = 2'd1,
    SRC_AUX  = 2'd2,
    SRC_BAT  = 2'd3
  } src_st_e;
endpackage

// File: rtl/bkup_bbm_seq.sv
module bkup_bbm_seq
  import bkup_pkg::*;
#(
  parameter int GAP_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic want_aux_i,
  input  logic hold_off_i,
  output logic aux_d_o,
  output logic bat_d_o,
  output logic aux_sw_o,
  output logic bat_sw_o
);
  localparam int CNT_W = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_N = CNT_W'(GAP_CYC);

  src_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] open_run;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (hold_off_i) begin
      st_d  = SRC_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        SRC_IDLE: begin
          st_d  = SRC_GAP;
          cnt_d = '0;
        end
        SRC_GAP: begin
          if (cnt_q == LAST) begin
            st_d  = want_aux_i ? SRC_AUX : SRC_BAT;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SRC_AUX: if (!want_aux_i) begin
          st_d  = SRC_GAP;
          cnt_d = '0;
        end
        SRC_BAT: if (want_aux_i) begin
          st_d  = SRC_GAP;
          cnt_d = '0;
        end
        default: begin
          st_d  = SRC_GAP;
          cnt_d = '0;
        end
      endcase
    end
  end

  assign aux_d_o = (st_d == SRC_AUX);
  assign bat_d_o = (st_d == SRC_BAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SRC_GAP;
      cnt_q    <= '0;
      aux_sw_o <= 1'b0;
      bat_sw_o <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      aux_sw_o <= aux_d_o;
      bat_sw_o <= bat_d_o;
    end
  end

  // Saturating count of cycles with both switches open, for the gap check.
  always_ff @(posedge clk) begin
    if (rst) begin
      open_run <= '0;
    end else if (!aux_sw_o && !bat_sw_o) begin
      if (open_run != GAP_N) open_run <= open_run + 1'b1;
    end else begin
      open_run <= '0;
    end
  end

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !(aux_sw_o && bat_sw_o));

  assert_full_gap_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(aux_sw_o) || $rose(bat_sw_o)) |-> (open_run == GAP_N));

  assert_aux_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (aux_sw_o && !want_aux_i) |=> !aux_sw_o);

  assert_bat_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (bat_sw_o && want_aux_i) |=> !bat_sw_o);
endmodule

// File: rtl/bkup_dormancy.sv
module bkup_dormancy (
  input  logic clk,
  input  logic rst,
  input  logic bat_sw_i,
  input  logic batt_low_i,
  input  logic aux_ok_i,
  input  logic reg_uvlo_i,
  output logic dorm_act_o,
  output logic dormant_o
);
  logic enter, wake;

  assign enter      = bat_sw_i && batt_low_i && !dormant_o;
  assign wake       = aux_ok_i && !reg_uvlo_i;
  assign dorm_act_o = enter || (dormant_o && !wake);

  always_ff @(posedge clk) begin
    if (rst) dormant_o <= 1'b0;
    else     dormant_o <= dorm_act_o;
  end

  assert_dorm_entry_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(dormant_o) |-> $past(bat_sw_i && batt_low_i));

  assert_dorm_exit_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(dormant_o) |-> $past(aux_ok_i && !reg_uvlo_i));
endmodule

// File: rtl/bkup_run_ctl.sv
module bkup_run_ctl (
  input  logic clk,
  input  logic rst,
  input  logic reg_en_n_i,
  input  logic reg_hot_i,
  input  logic reg_uvlo_i,
  input  logic dorm_act_i,
  input  logic src_next_i,
  output logic run_o
);
  always_ff @(posedge clk) begin
    if (rst) run_o <= 1'b0;
    else     run_o <= !reg_en_n_i && !reg_hot_i && !reg_uvlo_i
                      && !dorm_act_i && src_next_i;
  end

  assert_en_gate_R5: assert property (@(posedge clk) disable iff (rst)
    reg_en_n_i |=> !run_o);

  assert_hot_stop_R8: assert property (@(posedge clk) disable iff (rst)
    reg_hot_i |=> !run_o);

  assert_uvlo_stop_R10: assert property (@(posedge clk) disable iff (rst)
    reg_uvlo_i |=> !run_o);
endmodule

// File: rtl/bkup_src_ctrl.sv
module bkup_src_ctrl #(
  parameter int GAP_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic aux_ok_i,
  input  logic batt_low_i,
  input  logic reg_uvlo_i,
  input  logic reg_hot_i,
  input  logic reg_en_n_i,
  output logic aux_sw_o,
  output logic bat_sw_o,
  output logic reg_run_o,
  output logic dormant_o
);
  logic dorm_act;
  logic aux_d, bat_d;

  bkup_dormancy u_dorm (
    .clk        (clk),
    .rst        (rst),
    .bat_sw_i   (bat_sw_o),
    .batt_low_i (batt_low_i),
    .aux_ok_i   (aux_ok_i),
    .reg_uvlo_i (reg_uvlo_i),
    .dorm_act_o (dorm_act),
    .dormant_o  (dormant_o)
  );

  bkup_bbm_seq #(.GAP_CYC(GAP_CYC)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .want_aux_i (aux_ok_i),
    .hold_off_i (dorm_act),
    .aux_d_o    (aux_d),
    .bat_d_o    (bat_d),
    .aux_sw_o   (aux_sw_o),
    .bat_sw_o   (bat_sw_o)
  );

  bkup_run_ctl u_run (
    .clk        (clk),
    .rst        (rst),
    .reg_en_n_i (reg_en_n_i),
    .reg_hot_i  (reg_hot_i),
    .reg_uvlo_i (reg_uvlo_i),
    .dorm_act_i (dorm_act),
    .src_next_i (aux_d || bat_d),
    .run_o      (reg_run_o)
  );

  assert_run_needs_src_R5: assert property (@(posedge clk) disable iff (rst)
    reg_run_o |-> (aux_sw_o || bat_sw_o));

  assert_dorm_isolated_R6: assert property (@(posedge clk) disable iff (rst)
    dormant_o |-> (!aux_sw_o && !bat_sw_o && !reg_run_o));

  assert_aux_low_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (aux_sw_o && aux_ok_i) |=> (aux_sw_o && !dormant_o));
endmodule

// File: tb/bkup_src_ctrl_tb_top.sv
module bkup_src_ctrl_tb_top;
  localparam int G      = 16;
  localparam int WD_LIM = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aux_ok = 1'b1, batt_low = 1'b0, uvlo = 1'b0, hot = 1'b0, en_n = 1'b0;
  logic aux_sw, bat_sw, run, dorm;

  always #5 clk = ~clk;

  bkup_src_ctrl #(.GAP_CYC(G)) dut_i (
    .clk(clk), .rst(rst), .aux_ok_i(aux_ok), .batt_low_i(batt_low),
    .reg_uvlo_i(uvlo), .reg_hot_i(hot), .reg_en_n_i(en_n),
    .aux_sw_o(aux_sw), .bat_sw_o(bat_sw), .reg_run_o(run), .dormant_o(dorm)
  );

  typedef struct {
    int    cyc;
    logic  a, b, r, d;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int nchk = 0, nfail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Driver side: queue an expected output tuple due dly edges from now.
  task automatic expect_at(input int dly, input logic a, b, r, d, input string tag);
    exp_t e;
    e.cyc = cyc + dly; e.a = a; e.b = b; e.r = r; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive(input logic ax, bl, uv, ht, en);
    @(negedge clk); #1;
    aux_ok = ax; batt_low = bl; uvlo = uv; hot = ht; en_n = en;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  // Monitor side: compare tuples on their due cycle.
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        nchk++;
        if ({aux_sw, bat_sw, run, dorm} !== {q[i].a, q[i].b, q[i].r, q[i].d}) begin
          nfail++;
          $display("FAIL %s cyc %0d: got aux=%b bat=%b run=%b dorm=%b expected aux=%b bat=%b run=%b dorm=%b",
                   q[i].tag, cyc, aux_sw, bat_sw, run, dorm, q[i].a, q[i].b, q[i].r, q[i].d);
        end
        q.delete(i);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == WD_LIM) begin
      nfail++;
      $display("FAIL watchdog: run did not finish by cycle %0d", WD_LIM);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then first closure on auxiliary after G edges
    wait_cyc(2);
    @(negedge clk); #1;
    expect_at(1, 0, 0, 0, 0, "R1");
    wait_cyc(2);
    @(negedge clk); #1;
    rst = 1'b0;
    expect_at(G - 1, 0, 0, 0, 0, "R1");
    expect_at(G,     1, 0, 1, 0, "R1");
    wait_cyc(G + 3);

    // R2/R3: auxiliary to battery with full open gap
    drive(0, 0, 0, 0, 0);
    expect_at(1,     0, 0, 0, 0, "R2");
    expect_at(G,     0, 0, 0, 0, "R3");
    expect_at(G + 1, 0, 1, 1, 0, "R2");
    wait_cyc(G + 4);

    // R2: battery back to auxiliary
    drive(1, 0, 0, 0, 0);
    expect_at(1,     0, 0, 0, 0, "R2");
    expect_at(G,     0, 0, 0, 0, "R3");
    expect_at(G + 1, 1, 0, 1, 0, "R2");
    wait_cyc(G + 4);

    // R4: request flips back during the gap; gap still runs to completion
    drive(0, 0, 0, 0, 0);
    expect_at(1,     0, 0, 0, 0, "R4");
    expect_at(G,     0, 0, 0, 0, "R4");
    expect_at(G + 1, 1, 0, 1, 0, "R4");
    wait_cyc(3);
    drive(1, 0, 0, 0, 0);
    wait_cyc(G + 4);

    // R8: over-temperature stops run, switches stay
    drive(1, 0, 0, 1, 0);
    expect_at(1, 1, 0, 0, 0, "R8");
    wait_cyc(3);
    drive(1, 0, 0, 0, 0);
    expect_at(1, 1, 0, 1, 0, "R8");
    wait_cyc(3);

    // R5: enable deasserted stops run only
    drive(1, 0, 0, 0, 1);
    expect_at(1, 1, 0, 0, 0, "R5");
    wait_cyc(3);
    drive(1, 0, 0, 0, 0);
    expect_at(1, 1, 0, 1, 0, "R5");
    wait_cyc(3);

    // R10: undervoltage lockout stops run only
    drive(1, 0, 1, 0, 0);
    expect_at(1, 1, 0, 0, 0, "R10");
    wait_cyc(3);
    drive(1, 0, 0, 0, 0);
    expect_at(1, 1, 0, 1, 0, "R10");
    wait_cyc(3);

    // R9: low battery ignored while on auxiliary
    drive(1, 1, 0, 0, 0);
    expect_at(1, 1, 0, 1, 0, "R9");
    expect_at(5, 1, 0, 1, 0, "R9");
    wait_cyc(6);
    drive(1, 0, 0, 0, 0);
    wait_cyc(2);

    // Move onto battery, then R6: low battery enters dormancy
    drive(0, 0, 0, 0, 0);
    expect_at(G + 1, 0, 1, 1, 0, "R2");
    wait_cyc(G + 4);
    drive(0, 1, 0, 0, 0);
    expect_at(1, 0, 0, 0, 1, "R6");
    wait_cyc(3);

    // R7: latched against battery recovery and against aux with lockout
    drive(0, 0, 0, 0, 0);
    expect_at(1, 0, 0, 0, 1, "R7");
    expect_at(4, 0, 0, 0, 1, "R7");
    wait_cyc(5);
    drive(1, 0, 1, 0, 0);
    expect_at(1, 0, 0, 0, 1, "R7");
    expect_at(4, 0, 0, 0, 1, "R7");
    wait_cyc(5);
    drive(1, 0, 0, 0, 0);
    expect_at(1,     0, 0, 0, 0, "R7");
    expect_at(G,     0, 0, 0, 0, "R7");
    expect_at(G + 1, 1, 0, 1, 0, "R7");
    wait_cyc(G + 4);

    // R1: reset with auxiliary absent closes battery first
    @(negedge clk); #1;
    rst = 1'b1; aux_ok = 1'b0;
    expect_at(1, 0, 0, 0, 0, "R1");
    wait_cyc(3);
    @(negedge clk); #1;
    rst = 1'b0;
    expect_at(G - 1, 0, 0, 0, 0, "R1");
    expect_at(G,     0, 1, 1, 0, "R1");
    wait_cyc(G + 4);

    if (q.size() != 0) begin
      nfail++;
      $display("FAIL scoreboard: %0d expected items never compared, expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule